// File: doc/BRIEF.md
# Register-Driven Byte-Wide SPI Master

This block is a serial peripheral interface master run by software through four 32-bit registers in a small address window. It drives one data-out line and samples one data-in line, and moves exactly one byte per transfer, most significant bit first. Software starts a full-duplex exchange by writing the byte to send into the transmit register. It then polls a ready bit until the exchange is over and reads the received byte from the receive register. A receive-only exchange is made by sending 0x00.

Chip selects are not tied to transfers. Each select line follows its own enable bit in the control register, so software can keep a device selected across many bytes. The configuration register holds a 5-bit clock divider and the clock polarity and phase. It also holds a self-clearing flush command that empties the receive register. Two stored mode bits, a length select and a queue enable, read back as written; only the one-byte legacy behaviour is built.

Top module: `spi_legacy_master`

## Requirements
- R1: Registers are selected by byte address bits [3:2]: 0x0 control, 0x4 configuration, 0x8 transmit, 0xC receive. Configuration fields read back as written: divider in [4:0], length select in bit 5, phase in bit 6, polarity in bit 7, queue enable in bit 17. Read data appears on the bus one clock after the address is presented.
- R2: After reset all chip selects are inactive (high), the serial clock and data-out are low, control reads 0x00000002 and configuration reads 0.
- R3: A write to the transmit register while ready is 1 starts a transfer. The transfer shifts the written bits [7:0] out MSB first, one bit per bit time. Data-out is low whenever no transfer runs.
- R4: The receive register (bits [7:0]) holds the eight bits sampled from data-in during the last transfer, MSB first. It is valid once ready reads 1.
- R5: A write to the transmit register while ready reads 0 is ignored: no second transfer follows and the current one is unchanged.
- R6: A bit time lasts P input clocks, where P is the divider value and a value of 0 or 1 is taken as 2. The divider is captured when the transfer starts. Ready reads 0 for exactly 8*P consecutive clocks after the transmit write.
- R7: The serial clock rests at the polarity bit when idle. With phase 0, each bit time holds the rest level for its first floor(P/2) clocks and the opposite level for the rest. With phase 1 the order is swapped. Data-in is sampled at the clock edge that ends clock number floor(P/2) of each bit time.
- R8: Chip select n (active low) is asserted exactly while control bit 16+n is 1, whether or not a transfer runs.
- R9: Setting configuration bit 9 clears the receive register to 0 in the first clock with no transfer running, and the bit then reads back 0. While a transfer runs it reads back 1.
- R10: Control bit 1 is the ready flag and is read-only; writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions check on every cycle that a transfer begins only after a transmit write, and that a transfer lasts eight times the divider it captured. They also check that the captured divider does not move mid-transfer, that an idle serial clock rests at the polarity level, and that a pending flush clears once the line is idle. The state just after reset is checked the same way. The byte order on data-out and data-in, the phase-dependent sampling point and the ignored write during a busy transfer are shown only by the bench. The bench drives a device model that answers on the serial-clock edges, checks the pins clock by clock against its reference model, and reads the results back through the registers.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;
  // word index decoded from byte address bits [3:2]
  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_CFG  = 2'd1;
  localparam logic [1:0] W_TX   = 2'd2;
  localparam logic [1:0] W_RX   = 2'd3;

  localparam int WSEL_LSB   = 2;
  localparam int RDY_BIT    = 1;
  localparam int CS_LSB     = 16;
  localparam int PRESC_W    = 5;
  localparam int PRESC_LSB  = 0;
  localparam int LEN_BIT    = 5;
  localparam int PHA_BIT    = 6;
  localparam int POL_BIT    = 7;
  localparam int FLUSH_BIT  = 9;
  localparam int QUEUE_BIT  = 17;
  localparam int XFER_BITS  = 8;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               len_sel;
    logic               pha;
    logic               pol;
    logic               queue_en;
  } cfg_t;
endpackage

// File: rtl/spi_lm_regs.sv
module spi_lm_regs
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic [XFER_BITS-1:0] rx_byte,
  output cfg_t                 cfg,
  output logic [NUM_CS-1:0]    cs_en,
  output logic                 flush_pend,
  output logic                 flush_do,
  output logic                 start,
  output logic [XFER_BITS-1:0] tx_byte
);
  logic [1:0]        word;
  logic              wr_ctrl, wr_cfg;
  logic [DATA_W-1:0] rd_v;

  assign word     = bus_addr[WSEL_LSB +: 2];
  assign wr_ctrl  = bus_wr && (word == W_CTRL);
  assign wr_cfg   = bus_wr && (word == W_CFG);
  assign start    = bus_wr && (word == W_TX) && !busy;
  assign tx_byte  = bus_wdata[XFER_BITS-1:0];
  assign flush_do = flush_pend && !busy;

  always_comb begin
    rd_v = '0;
    unique case (word)
      W_CTRL: begin
        rd_v[RDY_BIT]           = ~busy;
        rd_v[CS_LSB +: NUM_CS]  = cs_en;
      end
      W_CFG: begin
        rd_v[PRESC_LSB +: PRESC_W] = cfg.presc;
        rd_v[LEN_BIT]              = cfg.len_sel;
        rd_v[PHA_BIT]              = cfg.pha;
        rd_v[POL_BIT]              = cfg.pol;
        rd_v[FLUSH_BIT]            = flush_pend;
        rd_v[QUEUE_BIT]            = cfg.queue_en;
      end
      W_RX:    rd_v[XFER_BITS-1:0] = rx_byte;
      default: rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_en      <= '0;
      cfg        <= '0;
      flush_pend <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rdata <= rd_v;
      if (wr_ctrl) cs_en <= bus_wdata[CS_LSB +: NUM_CS];
      if (wr_cfg) begin
        cfg.presc    <= bus_wdata[PRESC_LSB +: PRESC_W];
        cfg.len_sel  <= bus_wdata[LEN_BIT];
        cfg.pha      <= bus_wdata[PHA_BIT];
        cfg.pol      <= bus_wdata[POL_BIT];
        cfg.queue_en <= bus_wdata[QUEUE_BIT];
        flush_pend   <= bus_wdata[FLUSH_BIT];
      end else if (flush_do) begin
        flush_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_lm_engine.sv
module spi_lm_engine #(
  parameter int PRESC_W = 5,
  parameter int BITS    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BITS-1:0]    tx_byte,
  input  logic [PRESC_W-1:0] presc,
  input  logic               pol,
  input  logic               pha,
  input  logic               miso,
  input  logic               flush_do,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic [BITS-1:0]    rx_byte,
  output logic [PRESC_W-1:0] eff
);
  localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [PRESC_W-1:0] MIN_DIV  = PRESC_W'(2);
  localparam logic [BCW-1:0]     LAST_BIT = BCW'(BITS - 1);

  logic [PRESC_W-1:0] cnt_q, cnt_n, eff_n, half_q, half_n;
  logic [BCW-1:0]     bit_q, bit_n;
  logic [BITS-1:0]    tx_q, tx_n, sh_q, sh_n, rx_n;
  logic               busy_n, act_n, sclk_n, mosi_n;

  assign half_q = eff >> 1;

  always_comb begin
    busy_n = busy;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    eff_n  = eff;
    tx_n   = tx_q;
    sh_n   = sh_q;
    rx_n   = rx_byte;
    if (busy) begin
      if (cnt_q == half_q) sh_n = {sh_q[BITS-2:0], miso};
      if (cnt_q == eff - PRESC_W'(1)) begin
        cnt_n = '0;
        if (bit_q == LAST_BIT) begin
          busy_n = 1'b0;
          rx_n   = sh_n;
        end else begin
          bit_n = bit_q + BCW'(1);
        end
      end else begin
        cnt_n = cnt_q + PRESC_W'(1);
      end
    end else if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      bit_n  = '0;
      eff_n  = (presc < MIN_DIV) ? MIN_DIV : presc;
      tx_n   = tx_byte;
    end
    if (flush_do) rx_n = '0;
    half_n = eff_n >> 1;
    act_n  = pha ? (cnt_n < half_n) : (cnt_n >= half_n);
    sclk_n = busy_n ? (pol ^ act_n) : pol;
    mosi_n = busy_n ? tx_n[LAST_BIT - bit_n] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      bit_q   <= '0;
      eff     <= MIN_DIV;
      tx_q    <= '0;
      sh_q    <= '0;
      rx_byte <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      busy    <= busy_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      eff     <= eff_n;
      tx_q    <= tx_n;
      sh_q    <= sh_n;
      rx_byte <= rx_n;
      sclk    <= sclk_n;
      mosi    <= mosi_n;
    end
  end
endmodule

// File: rtl/spi_legacy_master.sv
module spi_legacy_master
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  cfg_t                 cfg_q;
  logic [NUM_CS-1:0]    cs_en;
  logic                 xfer_busy, flush_pend, flush_do, start;
  logic [XFER_BITS-1:0] tx_byte, rx_byte;
  logic [PRESC_W-1:0]   eff_div;

  spi_lm_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(xfer_busy),
    .rx_byte(rx_byte), .cfg(cfg_q), .cs_en(cs_en), .flush_pend(flush_pend),
    .flush_do(flush_do), .start(start), .tx_byte(tx_byte)
  );

  spi_lm_engine #(.PRESC_W(PRESC_W), .BITS(XFER_BITS)) u_eng (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte),
    .presc(cfg_q.presc), .pol(cfg_q.pol), .pha(cfg_q.pha), .miso(spi_miso),
    .flush_do(flush_do), .busy(xfer_busy), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx_byte(rx_byte), .eff(eff_div)
  );

  assign spi_cs_n = ~cs_en;
endmodule

// File: rtl/spi_lm_checker.sv
module spi_lm_checker
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              pol,
  input logic              sclk,
  input logic              flush_pend,
  input logic [PRESC_W-1:0] eff,
  input logic [NUM_CS-1:0] cs_n
);
  logic [15:0] run_cnt;
  logic [1:0]  word;
  assign word = bus_addr[WSEL_LSB +: 2];

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  assert_reset_state_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n == {NUM_CS{1'b1}} && !busy));

  assert_start_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && word == W_TX));

  assert_xfer_length_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_cnt == {8'd0, eff, 3'd0}));

  assert_div_held_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(eff));

  assert_idle_clock_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(pol)) |-> (sclk == pol));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (flush_pend && !busy && !(bus_wr && word == W_CFG)) |=> !flush_pend);
endmodule

bind spi_legacy_master spi_lm_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .busy(xfer_busy), .pol(cfg_q.pol), .sclk(spi_sclk), .flush_pend(flush_pend),
  .eff(eff_div), .cs_n(spi_cs_n)
);

// File: tb/test_spi_legacy_master.sv
module test_spi_legacy_master;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [NCS-1:0] spi_cs_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  spi_legacy_master #(.NUM_CS(NCS), .ADDR_W(4), .DATA_W(32)) i_spi_legacy_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model, advanced on every rising edge ----------
  bit       m_valid = 0;
  bit       m_busy;
  int       m_k, m_eff, m_presc;
  logic [7:0] m_tx;
  logic     m_pol, m_pha;
  logic [NCS-1:0] m_cs;
  logic     exp_sclk, exp_mosi, exp_ready;
  int       last_word;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_k = 0; m_eff = 2; m_presc = 0; m_tx = 0;
      m_pol = 0; m_pha = 0; m_cs = 0;
      exp_sclk = 0; exp_mosi = 0; exp_ready = 1; last_word = -1;
    end else begin
      int j, b, h;
      exp_ready = !m_busy;
      last_word = int'(bus_addr[3:2]);
      if (m_busy) begin
        m_k++;
        if (m_k == 8 * m_eff) m_busy = 0;
      end else if (bus_wr && bus_addr[3:2] == 2'd2) begin
        m_busy = 1; m_k = 0;
        m_eff = (m_presc < 2) ? 2 : m_presc;
        m_tx = bus_wdata[7:0];
      end
      j = m_k % m_eff; b = m_k / m_eff; h = m_eff / 2;
      exp_sclk = m_busy ? (m_pol ^ (m_pha ? (j < h) : (j >= h))) : m_pol;
      exp_mosi = m_busy ? m_tx[7-b] : 1'b0;
      if (bus_wr && bus_addr[3:2] == 2'd0) m_cs = bus_wdata[16 +: NCS];
      if (bus_wr && bus_addr[3:2] == 2'd1) begin
        m_presc = int'(bus_wdata[4:0]); m_pha = bus_wdata[6]; m_pol = bus_wdata[7];
      end
    end
    m_valid = 1;
  end

  // per-clock comparison of the pins against the model
  always @(negedge clk) begin
    if (m_valid && !done) begin
      check(spi_sclk === exp_sclk, "R7 sclk", {31'd0, spi_sclk}, {31'd0, exp_sclk});
      check(spi_mosi === exp_mosi, "R3 mosi", {31'd0, spi_mosi}, {31'd0, exp_mosi});
      check(spi_cs_n === ~m_cs, "R8 cs_n", {28'd0, spi_cs_n}, {28'd0, ~m_cs});
      if (last_word == 0)
        check(bus_rdata[1] === exp_ready, "R6 ready", {31'd0, bus_rdata[1]}, {31'd0, exp_ready});
    end
  end

  // ---------------- serial device model ------------------------------------
  logic [7:0] s_byte = 0;
  int   s_idx = 0;
  logic s_prev = 0, s_pol = 0, s_pha = 0;

  always @(negedge clk) begin
    if (spi_sclk !== s_prev) begin
      if (spi_sclk != s_pol) begin
        if (s_pha) begin
          spi_miso = (s_idx < 8) ? s_byte[7 - s_idx] : 1'b0;
          s_idx++;
        end
      end else if (!s_pha) begin
        s_idx++;
        spi_miso = (s_idx < 8) ? s_byte[7 - s_idx] : 1'b0;
      end
      s_prev = spi_sclk;
    end
  end

  task automatic slave_load(input logic [7:0] v, input logic pol, input logic pha);
    s_byte = v; s_idx = 0; s_pol = pol; s_pha = pha; s_prev = spi_sclk;
    spi_miso = pha ? 1'b0 : v[7];
  endtask

  // ---------------- bus tasks ---------------------------------------------
  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {w, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_addr = {w, 2'b00};
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 4'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (n < 4000) begin
      @(negedge clk);
      if (bus_rdata[1]) break;
      n++;
    end
  endtask

  function automatic logic [31:0] cfg_word(input int p, input logic pol, input logic pha);
    return 32'(p & 31) | (32'(pha) << 6) | (32'(pol) << 7);
  endfunction

  task automatic xfer(input int p, input logic pol, input logic pha,
                      input logic [7:0] tx, input logic [7:0] sb, input string tag);
    int n, e;
    logic [31:0] v;
    e = (p < 2) ? 2 : p;
    wr(2'd1, cfg_word(p, pol, pha));
    idle(3);
    slave_load(sb, pol, pha);
    wr(2'd2, {24'd0, tx});
    wait_ready(n);
    check(n == 8 * e, {"R6 busy clocks ", tag}, n, 8 * e);
    rd(2'd3, v);
    check(v == {24'd0, sb}, {"R4 received byte ", tag}, v, {24'd0, sb});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R2 reset state
    check(spi_cs_n == 4'hF, "R2 cs_n after reset", {28'd0, spi_cs_n}, 32'hF);
    check(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R2 sclk/mosi low", {30'd0, spi_sclk, spi_mosi}, 0);
    rd(2'd0, v); check(v == 32'h2, "R2 control after reset", v, 32'h2);
    rd(2'd1, v); check(v == 32'h0, "R2 config after reset", v, 32'h0);

    // R1 configuration field read-back
    wr(2'd1, 32'h0002_00E5);
    rd(2'd1, v); check(v == 32'h0002_00E5, "R1 config read-back", v, 32'h0002_00E5);
    wr(2'd1, 32'h0);
    rd(2'd2, v); check(v == 32'h0, "R1 transmit reads zero", v, 32'h0);

    // R10 ready bit read-only, R8 chip selects
    wr(2'd0, 32'h0001_0000);
    rd(2'd0, v); check(v == 32'h0001_0002, "R10 ready ignores write of 0", v, 32'h0001_0002);
    check(spi_cs_n == 4'b1110, "R8 select 0 only", {28'd0, spi_cs_n}, 32'hE);
    wr(2'd0, 32'h000A_0000);
    check(spi_cs_n == 4'b0101, "R8 selects 1 and 3", {28'd0, spi_cs_n}, 32'h5);
    wr(2'd0, 32'h0001_0002);

    // R3/R4/R6/R7 transfers in all modes and several dividers
    xfer(0,  1'b0, 1'b0, 8'hA5, 8'h3C, "div0 mode0");
    xfer(1,  1'b1, 1'b0, 8'h81, 8'h7E, "div1 mode2");
    xfer(5,  1'b0, 1'b1, 8'h00, 8'hC3, "div5 mode1 rx-only");
    xfer(4,  1'b1, 1'b1, 8'hFF, 8'h5A, "div4 mode3");
    xfer(31, 1'b0, 1'b0, 8'h96, 8'h69, "div31 mode0");
    xfer(3,  1'b0, 1'b1, 8'h5C, 8'hE1, "div3 mode1");

    // R5 write while busy is ignored
    wr(2'd1, cfg_word(4, 1'b0, 1'b0));
    idle(3);
    slave_load(8'hB4, 1'b0, 1'b0);
    wr(2'd2, 32'h0000_00C6);
    wr(2'd2, 32'h0000_0033);
    wait_ready(n);
    idle(4);
    rd(2'd0, v); check(v[1] == 1'b1, "R5 no second transfer", {31'd0, v[1]}, 1);
    rd(2'd3, v); check(v == 32'hB4, "R5 first transfer intact", v, 32'hB4);

    // R9 flush when idle
    wr(2'd1, cfg_word(4, 1'b0, 1'b0) | 32'h200);
    idle(2);
    rd(2'd1, v); check(v[9] == 1'b0, "R9 flush self-clears", {31'd0, v[9]}, 0);
    rd(2'd3, v); check(v == 32'h0, "R9 flush empties receive", v, 0);

    // R9 flush requested during a transfer waits for its end
    wr(2'd1, cfg_word(20, 1'b0, 1'b0));
    idle(3);
    slave_load(8'h4D, 1'b0, 1'b0);
    wr(2'd2, 32'h0000_0011);
    idle(5);
    wr(2'd1, cfg_word(20, 1'b0, 1'b0) | 32'h200);
    rd(2'd1, v); check(v[9] == 1'b1, "R9 flush pending while busy", {31'd0, v[9]}, 1);
    wait_ready(n);
    idle(2);
    rd(2'd1, v); check(v[9] == 1'b0, "R9 flush cleared after transfer", {31'd0, v[9]}, 0);
    rd(2'd3, v); check(v == 32'h0, "R9 receive cleared after transfer", v, 0);

    idle(3);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule